// File: doc/BRIEF.md
# Pitched Rectangle Copy Engine

This block moves a rectangular window of pixels from one linear surface in memory to another. Each surface has its own base byte address and row pitch. Software places the base addresses, pitches, pixel size code, the x/y origin on each surface, and the width and height in pixels on the configuration inputs. It then pulses `start`. The engine captures the whole job in that cycle and works out where the first byte sits on each surface. It then walks the rectangle one line at a time. For every byte it issues a one-byte read to the source, waits for the returned data, and writes that byte unchanged to the destination. All traffic goes over one valid/ready request port with a separate read-response strobe.

Tall jobs are split into chunks. A chunk holds at most `CHUNK_LINES` lines. After a chunk ends, each surface's chunk base moves forward by its own pitch times the line count of that chunk. The engine raises `busy` while a job runs and pulses `done` once when the job is finished.

Top module: `pitched_blit`

## Requirements
- R1: The first source byte address of a job is src_base + src_y*src_pitch + src_x*bpp. The first destination byte address is dst_base + dst_y*dst_pitch + dst_x*bpp. The sums are taken modulo 2^AW.
- R2: Each line moves width*bpp bytes at consecutive addresses on both surfaces, one byte per request, and the data is written unchanged.
- R3: Successive lines step by each surface's own pitch. Source and destination pitches are independent of each other.
- R4: A chunk covers at most CHUNK_LINES lines. When a chunk ends, each surface's chunk base advances by its pitch times that chunk's line count. Chunks follow one another until the remaining height reaches zero, so every one of the height lines is copied exactly once.
- R5: A job with a width of zero or a height of zero issues no memory request. Its `done` is high in the cycle right after the edge that accepted `start`.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request (valid, write flag, address, write data) stays unchanged into the next cycle.
- R7: At most one read is outstanding. Every accepted read is followed by exactly one write before the next read is issued.
- R8: `start` is ignored while `busy` is high. Changing the configuration inputs during a job does not change that job's traffic.
- R9: `busy` goes high in the cycle after a non-empty job is accepted. `done` is a single-cycle pulse in the cycle after the last write is accepted. `busy` drops in the cycle after `done`.
- R10: `bpp_code` selects the pixel size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and code 3 also gives 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job start pulse, sampled in idle |
| src_base | input | AW | Source surface base byte address |
| dst_base | input | AW | Destination surface base byte address |
| src_pitch | input | PW | Source row pitch in bytes |
| dst_pitch | input | PW | Destination row pitch in bytes |
| bpp_code | input | 2 | Pixel size code (see R10) |
| src_x | input | CW | Source origin column in pixels |
| src_y | input | CW | Source origin row |
| dst_x | input | CW | Destination origin column in pixels |
| dst_y | input | CW | Destination origin row |
| width | input | CW | Rectangle width in pixels |
| height | input | CW | Rectangle height in lines |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | AW | Request byte address |
| mem_req_wdata | output | 8 | Write data byte |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |

## Verification
The bench sweeps every pixel size code, widths 0 to 3 and heights 0 to 7. It uses a chunk limit of 3, so that heights of 4 and 7 cross one or two chunk boundaries. If the chunk-base update were wrong, the lines after a boundary would land on the wrong rows. An off-by-one in the line count would also show up as a missing or duplicated line in the final byte count. Each job uses different pitches on the two surfaces, so a design that stepped both surfaces by the same pitch would write bytes to the wrong destination addresses. Empty rectangles are checked for zero traffic and for `done` arriving in the very next cycle. A `start` pulse with a different configuration is injected in the middle of a job; a design that re-latched it would change the byte count or the destination addresses. The memory model pulls ready low in an irregular pattern to exercise the request-hold rule.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_WRITE,
      ST_FIN
   } pbl_state_e;

   // pixel size code to byte shift; code 3 aliases the 4-byte size
   function automatic logic [1:0] bpp_shift(input logic [1:0] code);
      case (code)
         2'd0:    bpp_shift = 2'd0;
         2'd1:    bpp_shift = 2'd1;
         default: bpp_shift = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/pbl_addr_gen.sv
module pbl_addr_gen #(
   parameter int AW = 32,
   parameter int CW = 12,
   parameter int PW = 16
) (
   input  logic [AW-1:0] base,
   input  logic [PW-1:0] pitch,
   input  logic [CW-1:0] org_x,
   input  logic [CW-1:0] org_y,
   input  logic [1:0]    shift,
   output logic [AW-1:0] start_addr
);
   localparam int YW = PW + CW;
   localparam int XW = CW + 2;

   logic [YW-1:0] row_off;
   logic [XW-1:0] col_off;

   assign row_off    = YW'(org_y) * YW'(pitch);
   assign col_off    = XW'(org_x) << shift;
   assign start_addr = base + AW'(row_off) + AW'(col_off);
endmodule

// File: rtl/pbl_walker.sv
module pbl_walker #(
   parameter int AW = 32,
   parameter int PW = 16,
   parameter int NW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [PW-1:0] load_pitch,
   input  logic          next_line,
   input  logic          next_chunk,
   input  logic [NW-1:0] chunk_lines,
   output logic [AW-1:0] line_addr
);
   localparam int MW = PW + NW;

   logic [AW-1:0] chunk_base_q;
   logic [AW-1:0] line_q;
   logic [PW-1:0] pitch_q;
   logic [MW-1:0] chunk_adv;
   logic [AW-1:0] next_base;

   assign chunk_adv = MW'(pitch_q) * MW'(chunk_lines);
   assign next_base = chunk_base_q + AW'(chunk_adv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chunk_base_q <= '0;
         line_q       <= '0;
         pitch_q      <= '0;
      end else if (load) begin
         chunk_base_q <= load_addr;
         line_q       <= load_addr;
         pitch_q      <= load_pitch;
      end else if (next_chunk) begin
         chunk_base_q <= next_base;
         line_q       <= next_base;
      end else if (next_line) begin
         line_q <= line_q + AW'(pitch_q);
      end
   end

   assign line_addr = line_q;
endmodule

// File: rtl/pitched_blit.sv
module pitched_blit
   import pbl_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 12,
   parameter int PW          = 16,
   parameter int CHUNK_LINES = 2047
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] src_base,
   input  logic [AW-1:0] dst_base,
   input  logic [PW-1:0] src_pitch,
   input  logic [PW-1:0] dst_pitch,
   input  logic [1:0]    bpp_code,
   input  logic [CW-1:0] src_x,
   input  logic [CW-1:0] src_y,
   input  logic [CW-1:0] dst_x,
   input  logic [CW-1:0] dst_y,
   input  logic [CW-1:0] width,
   input  logic [CW-1:0] height,
   output logic          busy,
   output logic          done,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [7:0]    mem_req_wdata,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [7:0]    mem_rsp_data
);
   localparam int LBW = CW + 2;
   localparam int NW  = $clog2(CHUNK_LINES + 1);
   localparam int NSURF = 2;

   if (CHUNK_LINES < 1) begin : g_bad_chunk
      $error("CHUNK_LINES must be at least 1");
   end
   if (AW < 8 || CW < 1 || PW < 1) begin : g_bad_width
      $error("address, coordinate and pitch widths too small");
   end

   function automatic logic [NW-1:0] take_chunk(input logic [CW-1:0] left);
      if (32'(left) > CHUNK_LINES) take_chunk = NW'(CHUNK_LINES);
      else                         take_chunk = NW'(left);
   endfunction

   pbl_state_e    state_q;
   logic [LBW-1:0] line_bytes_q;
   logic [LBW-1:0] byte_q;
   logic [CW-1:0]  rem_q;
   logic [NW-1:0]  chunk_n_q;
   logic [NW-1:0]  line_k_q;
   logic [7:0]     data_q;

   logic [1:0]     shift;
   logic           accept;
   logic           empty_job;
   logic           wr_fire;
   logic           line_end;
   logic           chunk_end;
   logic           job_end;
   logic           step_line;
   logic           step_chunk;

   logic [NSURF-1:0][AW-1:0] base_v;
   logic [NSURF-1:0][PW-1:0] pitch_v;
   logic [NSURF-1:0][CW-1:0] x_v;
   logic [NSURF-1:0][CW-1:0] y_v;
   logic [NSURF-1:0][AW-1:0] start_v;
   logic [NSURF-1:0][AW-1:0] line_v;

   assign base_v  = {dst_base,  src_base};
   assign pitch_v = {dst_pitch, src_pitch};
   assign x_v     = {dst_x,     src_x};
   assign y_v     = {dst_y,     src_y};

   assign shift     = bpp_shift(bpp_code);
   assign accept    = (state_q == ST_IDLE) && start;
   assign empty_job = (width == '0) || (height == '0);

   assign wr_fire    = (state_q == ST_WRITE) && mem_req_ready;
   assign line_end   = (byte_q == line_bytes_q - LBW'(1));
   assign chunk_end  = line_end && (line_k_q == chunk_n_q - NW'(1));
   assign job_end    = chunk_end && (CW'(chunk_n_q) == rem_q);
   assign step_line  = wr_fire && line_end && !chunk_end;
   assign step_chunk = wr_fire && chunk_end && !job_end;

   // one address generator and one line walker per surface (0 = source, 1 = destination)
   for (genvar s = 0; s < NSURF; s++) begin : g_surf
      pbl_addr_gen #(.AW(AW), .CW(CW), .PW(PW)) u_agen (
         .base       (base_v[s]),
         .pitch      (pitch_v[s]),
         .org_x      (x_v[s]),
         .org_y      (y_v[s]),
         .shift      (shift),
         .start_addr (start_v[s])
      );
      pbl_walker #(.AW(AW), .PW(PW), .NW(NW)) u_walk (
         .clk         (clk),
         .rst_n       (rst_n),
         .load        (accept),
         .load_addr   (start_v[s]),
         .load_pitch  (pitch_v[s]),
         .next_line   (step_line),
         .next_chunk  (step_chunk),
         .chunk_lines (chunk_n_q),
         .line_addr   (line_v[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         line_bytes_q <= '0;
         byte_q       <= '0;
         rem_q        <= '0;
         chunk_n_q    <= '0;
         line_k_q     <= '0;
         data_q       <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               line_bytes_q <= LBW'(width) << shift;
               byte_q       <= '0;
               line_k_q     <= '0;
               rem_q        <= height;
               chunk_n_q    <= take_chunk(height);
               state_q      <= empty_job ? ST_FIN : ST_READ;
            end
            ST_READ: if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               data_q  <= mem_rsp_data;
               state_q <= ST_WRITE;
            end
            ST_WRITE: if (mem_req_ready) begin
               if (!line_end) begin
                  byte_q  <= byte_q + LBW'(1);
                  state_q <= ST_READ;
               end else if (job_end) begin
                  state_q <= ST_FIN;
               end else if (chunk_end) begin
                  byte_q    <= '0;
                  line_k_q  <= '0;
                  rem_q     <= rem_q - CW'(chunk_n_q);
                  chunk_n_q <= take_chunk(rem_q - CW'(chunk_n_q));
                  state_q   <= ST_READ;
               end else begin
                  byte_q   <= '0;
                  line_k_q <= line_k_q + NW'(1);
                  state_q  <= ST_READ;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign done          = (state_q == ST_FIN);
   assign mem_req_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_req_write = (state_q == ST_WRITE);
   assign mem_req_addr  = (state_q == ST_WRITE) ? line_v[1] + AW'(byte_q)
                                                : line_v[0] + AW'(byte_q);
   assign mem_req_wdata = data_q;
endmodule

// File: rtl/pbl_chk.sv
module pbl_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          mem_req_valid,
   input logic          mem_req_write,
   input logic [AW-1:0] mem_req_addr,
   input logic [7:0]    mem_req_wdata,
   input logic          mem_req_ready
);
   logic rd_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          rd_pend_q <= 1'b0;
      else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend_q <= 1'b1;
      else if (mem_req_valid && mem_req_ready && mem_req_write)  rd_pend_q <= 1'b0;
   end

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)
          && $stable(mem_req_wdata)));

   // R7
   one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> !rd_pend_q);

   // R7
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> rd_pend_q);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy || done) |-> !mem_req_valid);
endmodule

bind pitched_blit pbl_chk #(.AW(AW)) u_pbl_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .mem_req_ready (mem_req_ready)
);

// File: tb/test_pitched_blit.sv
module test_pitched_blit;
   localparam int AW = 16;
   localparam int CW = 8;
   localparam int PW = 8;
   localparam int CHUNK = 3;
   localparam int MEMN = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_base = '0, dst_base = '0;
   logic [PW-1:0] src_pitch = '0, dst_pitch = '0;
   logic [1:0]    bpp_code = '0;
   logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
   logic [CW-1:0] width = '0, height = '0;
   logic          busy, done;
   logic          mem_req_valid, mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [7:0]    mem_req_wdata;
   logic          mem_req_ready = 1'b0;
   logic          mem_rsp_valid = 1'b0;
   logic [7:0]    mem_rsp_data = '0;

   int n_checks = 0;
   int n_fail = 0;

   logic [7:0] dmem  [MEMN];
   logic       wflag [MEMN];
   int  nrd, nwr, ndone, nstray;
   int  first_rd, first_wr;
   logic [7:0] rdy_lfsr = 8'hA5;

   always #5 clk = ~clk;

   pitched_blit #(.AW(AW), .CW(CW), .PW(PW), .CHUNK_LINES(CHUNK)) i_pitched_blit (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_base(src_base), .dst_base(dst_base),
      .src_pitch(src_pitch), .dst_pitch(dst_pitch), .bpp_code(bpp_code),
      .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
      .width(width), .height(height), .busy(busy), .done(done),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [7:0] src_byte(input int a);
      logic [15:0] v;
      v = 16'(a);
      return v[7:0] ^ {v[11:8], v[11:8]} ^ 8'h5A;
   endfunction

   // memory model: irregular ready, read data one cycle after acceptance
   always @(posedge clk) begin
      rdy_lfsr <= {rdy_lfsr[6:0], rdy_lfsr[7] ^ rdy_lfsr[5] ^ rdy_lfsr[4] ^ rdy_lfsr[3]};
      mem_req_ready <= rdy_lfsr[0] | rdy_lfsr[2];
      mem_rsp_valid <= 1'b0;
      if (done) ndone = ndone + 1;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            if (nwr == 0) first_wr = int'(mem_req_addr);
            nwr = nwr + 1;
            if (int'(mem_req_addr) < MEMN) begin
               dmem[int'(mem_req_addr)]  = mem_req_wdata;
               wflag[int'(mem_req_addr)] = 1'b1;
            end else nstray = nstray + 1;
         end else begin
            if (nrd == 0) first_rd = int'(mem_req_addr);
            nrd = nrd + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= src_byte(int'(mem_req_addr));
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_job(input int sb, input int db, input int sp, input int dp,
                          input int code, input int sx, input int sy,
                          input int dx, input int dy, input int w, input int h,
                          input int poke_at);
      int bpp, nbytes, bad, cyc, d_at_start;
      bpp = (code == 0) ? 1 : (code == 1) ? 2 : 4;
      nbytes = w * bpp * h;
      for (int i = 0; i < MEMN; i++) wflag[i] = 1'b0;
      @(negedge clk);
      nrd = 0; nwr = 0; ndone = 0; nstray = 0; first_rd = -1; first_wr = -1;
      src_base = AW'(sb); dst_base = AW'(db); src_pitch = PW'(sp); dst_pitch = PW'(dp);
      bpp_code = 2'(code); src_x = CW'(sx); src_y = CW'(sy); dst_x = CW'(dx); dst_y = CW'(dy);
      width = CW'(w); height = CW'(h);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      d_at_start = int'(done);
      if (w == 0 || h == 0) begin
         // R5: done in the cycle right after the accepting edge
         check(done == 1'b1, "R5 done timing", d_at_start, 1);
      end else begin
         // R9: busy set, done low one cycle after start
         check(busy == 1'b1 && done == 1'b0, "R9 busy after start", int'({busy, done}), 2);
      end
      cyc = 0;
      while (busy && cyc < 5000) begin
         if (poke_at != 0 && cyc == poke_at) begin
            // R8: a second start with a different job while busy
            dst_base = AW'(db + 700); width = 8'd1; height = 8'd1; dst_pitch = 8'd5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end else @(negedge clk);
         cyc++;
      end
      check(cyc < 5000, "R9 job completes", cyc, 0);
      repeat (6) @(negedge clk);
      check(!busy, "R8 no restart from start while busy", int'(busy), 0);
      check(ndone == 1, "R9 single done pulse", ndone, 1);
      // R5 zero traffic / R2 byte counts
      check(nwr == nbytes && nrd == nbytes, "R2 R4 R5 byte count", nwr, nbytes);
      check(nstray == 0, "R2 stray write", nstray, 0);
      if (nbytes > 0) begin
         // R1 and R10: start addresses with the decoded pixel size
         check(first_rd == sb + sy * sp + sx * bpp, "R1 R10 source start", first_rd,
               sb + sy * sp + sx * bpp);
         check(first_wr == db + dy * dp + dx * bpp, "R1 R10 dest start", first_wr,
               db + dy * dp + dx * bpp);
         bad = 0;
         for (int y = 0; y < h; y++) begin
            for (int b = 0; b < w * bpp; b++) begin
               int da, sa;
               da = db + (dy + y) * dp + dx * bpp + b;
               sa = sb + (sy + y) * sp + sx * bpp + b;
               if (!wflag[da] || dmem[da] !== src_byte(sa)) begin
                  if (bad == 0)
                     $display("FAIL R2 R3 R4 data at line %0d byte %0d actual=%0d expected=%0d",
                              y, b, dmem[da], src_byte(sa));
                  bad++;
               end
            end
         end
         // R2 R3 R4: every byte of every line and chunk in place
         n_checks++;
         if (bad != 0) n_fail++;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check(busy == 1'b0 && done == 1'b0 && mem_req_valid == 1'b0,
            "R9 reset outputs", int'({busy, done, mem_req_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && mem_req_valid == 1'b0, "R9 idle after reset",
            int'({busy, mem_req_valid}), 0);

      // sweep pixel size, width and height; heights above 3 cross chunk boundaries (R4)
      for (int c = 0; c < 3; c++) begin
         for (int w = 0; w < 4; w++) begin
            for (int h = 0; h < 8; h++) begin
               run_job(16 + c * 5, 2000 + h * 3, 40 + w * 3, 60 - c * 4, c,
                       (w + h) % 3, h % 2, (h + 1) % 2, c, w, h, 0);
            end
         end
      end
      // R10: code 3 behaves as 4 bytes per pixel
      run_job(100, 2500, 50, 37, 3, 2, 1, 1, 2, 3, 5, 0);
      // R8: start pulse with new config in the middle of a job
      run_job(30, 1500, 64, 48, 1, 1, 2, 3, 1, 3, 7, 20);
      run_job(30, 1500, 64, 48, 0, 0, 0, 0, 0, 2, 4, 3);
      // R3: very different pitches per surface
      run_job(0, 3000, 9, 77, 1, 0, 3, 1, 0, 2, 6, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule